// File: doc/BRIEF.md
# Dual-Tone and Single-Tone Generator with Buzzer Bitstream

This block synthesizes audio tones for a handset receive path. Two independent tone channels, a high one and a low one, each take an 8-bit frequency code. Each channel advances a phase accumulator on every pulse of a 2.048 MHz clock enable. One code step is about 7.81 Hz. The two channel waveforms are summed into one signed sample. Loading only one channel plays a single tone. Loading both plays a dual-tone (DTMF) pair, with the higher frequency in the high channel. The high channel is scaled to come out about 2 dB louder than the low one.

The summed sample goes to the receive path with a one-cycle valid strobe. The same sample also drives a first-order sigma-delta modulator, whose carry bit is a pulse-density bitstream for a buzzer driver. A code of zero mutes its channel and freezes that channel's phase. Dropping the enable silences everything and clears all running state, so the next tone starts from phase zero.

Top module: `tone_gen_dtmf`

## Requirements
- R1: On each clock-enable pulse while enabled, each channel with a nonzero code adds its code to an 18-bit phase that wraps modulo 2^18. The sample presented after the k-th pulse is computed from the phases as they stood before that pulse, that is, after k-1 steps.
- R2: Waveform: the index is phase bits [17:10]. Let h = index[6:0]. The magnitude is h*(128-h), and it is negated when index[7] is 1. The low channel contributes this value unchanged.
- R3: The high channel contributes floor(h*(128-h)*161/128) for the same index, negated when index[7] is 1. The sign is applied after scaling, which gives about +2 dB over the low channel.
- R4: sample_o is the 16-bit two's-complement sum of both channel contributions. It changes only on an enabled clock-enable pulse.
- R5: A code of 0 makes its channel contribute 0 and holds that channel's phase. Restoring a nonzero code resumes from the held phase.
- R6: sample_vld_o is high in exactly the clock cycle after each cycle in which ce_i and en_i are both high, and low otherwise.
- R7: buzz_o is the carry out of a 16-bit accumulator. On each enabled pulse the accumulator adds the current sample_o plus 32768, taken modulo 2^16. With sample 0 from a cleared state, the bitstream is 0,1,0,1,… Over any whole tone period the ones density is exactly one half.
- R8: While en_i is low, both phases, the sample and the accumulator are cleared, buzz_o and sample_vld_o are low, and ce_i is ignored.
- R9: After reset (rst_n low, asynchronous), sample_o is 0 and sample_vld_o and buzz_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | 2.048 MHz clock-enable pulse |
| en_i | input | 1 | Generator enable; low clears and silences |
| hi_code_i | input | 8 | High-channel frequency code (0 = off) |
| lo_code_i | input | 8 | Low-channel frequency code (0 = off) |
| sample_o | output | 16 | Signed summed tone sample |
| sample_vld_o | output | 1 | One-cycle strobe after each enabled pulse |
| buzz_o | output | 1 | Pulse-density buzzer bitstream |

## Verification
The bench targets the phase wrap at the top code. There, a design that mishandled the 18-bit modulus would give a nonzero sample where the index returns to zero. It also targets the negative half-wave and the high-channel scaling: a missing or misplaced sign, or scaling applied after negation with the wrong rounding, shows up as an off-by-one or wrong-signed sample. A code-zero hold followed by a restore exposes a channel that resets or keeps advancing its phase. The bench also disables the generator in mid-tone and then re-enables it, which shows whether the state really cleared. Exact ones counts on the buzzer, over a silent stretch and over one full tone period, catch any bias in the offset-binary conversion or the carry.

// File: rtl/tone_gen_pkg.sv
package tone_gen_pkg;
   localparam int unsigned CH_LO = 0;
   localparam int unsigned CH_HI = 1;
   localparam int unsigned CH_N  = 2;

   // peak of h*(HALF-h) for an index of idx_w bits
   function automatic longint peak_mag(input int unsigned idx_w);
      return longint'(1) << (2 * idx_w - 4);
   endfunction

   function automatic longint scaled_peak(input int unsigned idx_w,
                                          input int unsigned gnum,
                                          input int unsigned gshift);
      return (peak_mag(idx_w) * longint'(gnum)) >>> gshift;
   endfunction
endpackage

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
   parameter int unsigned PHASE_W = 18,
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned IDX_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              ce_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic              active_o
);
   generate
      if (CODE_W >= PHASE_W) begin : g_bad_code
         $error("tone_phase_acc: CODE_W must be below PHASE_W");
      end
      if (IDX_W > PHASE_W) begin : g_bad_idx
         $error("tone_phase_acc: IDX_W must not exceed PHASE_W");
      end
   endgenerate

   logic [PHASE_W-1:0] phase_q;
   logic               step_en;

   assign active_o = (code_i != '0);
   assign step_en  = ce_i && active_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!en_i) begin
         phase_q <= '0;
      end else if (step_en) begin
         phase_q <= phase_q + PHASE_W'(code_i);
      end
   end

   assign idx_o = phase_q[PHASE_W-1 -: IDX_W];

   // R1: phase advances by exactly the code, modulo 2^PHASE_W
   a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && ce_i && code_i != '0) |=>
         (phase_q == $past(phase_q) + PHASE_W'($past(code_i))));

   // R5: a zero code freezes the phase
   a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && code_i == '0) |=> $stable(phase_q));

   // R8: disabling clears the phase
   a_r8_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (phase_q == '0));
endmodule

// File: rtl/tone_wave_shaper.sv
module tone_wave_shaper #(
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned SAMP_W     = 16,
   parameter int unsigned GAIN_NUM   = 128,
   parameter int unsigned GAIN_SHIFT = 7
) (
   input  logic [IDX_W-1:0]         idx_i,
   input  logic                     active_i,
   output logic signed [SAMP_W-1:0] amp_o
);
   import tone_gen_pkg::*;

   localparam int unsigned HALF_W = IDX_W - 1;
   localparam int unsigned MAG_W  = 2 * HALF_W + 1;
   localparam int unsigned GAIN_W = $clog2(GAIN_NUM + 1);
   localparam int unsigned PROD_W = MAG_W + GAIN_W;
   localparam longint      PEAK_OUT = scaled_peak(IDX_W, GAIN_NUM, GAIN_SHIFT);

   generate
      if (IDX_W < 3) begin : g_bad_idx
         $error("tone_wave_shaper: IDX_W must be at least 3");
      end
      if (2 * PEAK_OUT >= (longint'(1) << (SAMP_W - 1))) begin : g_bad_samp
         $error("tone_wave_shaper: SAMP_W too narrow for two summed channels");
      end
   endgenerate

   logic [HALF_W-1:0]      half_pos;
   logic [HALF_W:0]        half_rem;
   logic [MAG_W-1:0]       mag;
   logic [PROD_W-1:0]      scaled;
   logic signed [SAMP_W-1:0] mag_s;
   logic                   neg_half;

   assign neg_half = idx_i[IDX_W-1];
   assign half_pos = idx_i[HALF_W-1:0];
   assign half_rem = (HALF_W+1)'(1 << HALF_W) - {1'b0, half_pos};
   assign mag      = MAG_W'(half_pos) * MAG_W'(half_rem);

   generate
      if (GAIN_NUM == (1 << GAIN_SHIFT)) begin : g_unity
         assign scaled = PROD_W'(mag);
      end else begin : g_boost
         logic [PROD_W-1:0] full;
         assign full   = PROD_W'(mag) * PROD_W'(GAIN_NUM);
         assign scaled = full >> GAIN_SHIFT;
      end
   endgenerate

   assign mag_s = SAMP_W'(scaled);

   always_comb begin
      if (!active_i) begin
         amp_o = '0;
      end else if (neg_half) begin
         amp_o = -mag_s;
      end else begin
         amp_o = mag_s;
      end
   end
endmodule

// File: rtl/tone_pdm_mod.sv
module tone_pdm_mod #(
   parameter int unsigned SAMP_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic                     ce_i,
   input  logic signed [SAMP_W-1:0] sample_i,
   output logic                     bit_o
);
   generate
      if (SAMP_W < 2) begin : g_bad_w
         $error("tone_pdm_mod: SAMP_W must be at least 2");
      end
   endgenerate

   logic [SAMP_W-1:0] acc_q;
   logic [SAMP_W-1:0] offs;
   logic [SAMP_W:0]   acc_nxt;

   // two's complement to offset binary
   assign offs    = {~sample_i[SAMP_W-1], sample_i[SAMP_W-2:0]};
   assign acc_nxt = {1'b0, acc_q} + {1'b0, offs};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         bit_o <= 1'b0;
      end else if (!en_i) begin
         acc_q <= '0;
         bit_o <= 1'b0;
      end else if (ce_i) begin
         acc_q <= acc_nxt[SAMP_W-1:0];
         bit_o <= acc_nxt[SAMP_W];
      end
   end

   // R7: a zero sample from a cleared accumulator lands at mid-scale with no carry
   a_r7_mid_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && ce_i && sample_i == '0 && acc_q == '0) |=>
         (!bit_o && acc_q == SAMP_W'(1 << (SAMP_W - 1))));

   // R8: a disabled modulator is silent
   a_r8_pdm_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!bit_o && acc_q == '0));
endmodule

// File: rtl/tone_gen_dtmf.sv
module tone_gen_dtmf #(
   parameter int unsigned PHASE_W     = 18,
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned IDX_W       = 8,
   parameter int unsigned SAMP_W      = 16,
   parameter int unsigned HI_GAIN_NUM = 161,
   parameter int unsigned GAIN_SHIFT  = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ce_i,
   input  logic                     en_i,
   input  logic [CODE_W-1:0]        hi_code_i,
   input  logic [CODE_W-1:0]        lo_code_i,
   output logic signed [SAMP_W-1:0] sample_o,
   output logic                     sample_vld_o,
   output logic                     buzz_o
);
   import tone_gen_pkg::*;

   localparam int unsigned UNITY    = 1 << GAIN_SHIFT;
   localparam longint      PEAK_SUM = scaled_peak(IDX_W, UNITY, GAIN_SHIFT)
                                    + scaled_peak(IDX_W, HI_GAIN_NUM, GAIN_SHIFT);

   generate
      if (HI_GAIN_NUM < UNITY) begin : g_bad_gain
         $error("tone_gen_dtmf: high channel must not be quieter than low");
      end
   endgenerate

   logic [CODE_W-1:0]        code_w [CH_N];
   logic [IDX_W-1:0]         idx_w  [CH_N];
   logic                     act_w  [CH_N];
   logic signed [SAMP_W-1:0] amp_w  [CH_N];
   logic signed [SAMP_W-1:0] sum_w;
   logic                     fire;

   assign code_w[CH_LO] = lo_code_i;
   assign code_w[CH_HI] = hi_code_i;

   generate
      for (genvar c = 0; c < CH_N; c++) begin : g_ch
         localparam int unsigned GNUM = (c == CH_HI) ? HI_GAIN_NUM : UNITY;

         tone_phase_acc #(
            .PHASE_W (PHASE_W),
            .CODE_W  (CODE_W),
            .IDX_W   (IDX_W)
         ) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en_i),
            .ce_i     (ce_i),
            .code_i   (code_w[c]),
            .idx_o    (idx_w[c]),
            .active_o (act_w[c])
         );

         tone_wave_shaper #(
            .IDX_W      (IDX_W),
            .SAMP_W     (SAMP_W),
            .GAIN_NUM   (GNUM),
            .GAIN_SHIFT (GAIN_SHIFT)
         ) u_shape (
            .idx_i    (idx_w[c]),
            .active_i (act_w[c]),
            .amp_o    (amp_w[c])
         );
      end
   endgenerate

   assign sum_w = amp_w[CH_LO] + amp_w[CH_HI];
   assign fire  = ce_i && en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_o     <= '0;
         sample_vld_o <= 1'b0;
      end else begin
         sample_vld_o <= fire;
         if (!en_i) begin
            sample_o <= '0;
         end else if (ce_i) begin
            sample_o <= sum_w;
         end
      end
   end

   tone_pdm_mod #(
      .SAMP_W (SAMP_W)
   ) u_pdm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .ce_i     (ce_i),
      .sample_i (sample_o),
      .bit_o    (buzz_o)
   );

   // R6: strobe only after an enabled pulse
   a_r6_vld_source: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld_o |-> $past(ce_i && en_i));

   // R6: every enabled pulse yields a strobe
   a_r6_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && en_i) |=> sample_vld_o);

   // R4: sample holds between enabled pulses
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !ce_i) |=> $stable(sample_o));

   // R4: summed sample stays within the two-channel peak
   a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'(sample_o) <= PEAK_SUM) && (longint'(sample_o) >= -PEAK_SUM));

   // R8: disabled generator is quiet at the ports
   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!sample_vld_o && !buzz_o && sample_o == '0));
endmodule

// File: tb/tone_gen_dtmf_bench.sv
`timescale 1ns/1ps
module tone_gen_dtmf_bench;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce = 1'b0;
   logic              en = 1'b0;
   logic [7:0]        hi_code = '0;
   logic [7:0]        lo_code = '0;
   logic signed [15:0] sample;
   logic              vld;
   logic              buzz;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tone_gen_dtmf u_tone_gen_dtmf (
      .clk          (clk),
      .rst_n        (rst_n),
      .ce_i         (ce),
      .en_i         (en),
      .hi_code_i    (hi_code),
      .lo_code_i    (lo_code),
      .sample_o     (sample),
      .sample_vld_o (vld),
      .buzz_o       (buzz)
   );

   // vectors: high code, low code, pulses after a fresh enable, expected sample
   localparam int VEC_N = 10;
   localparam int V_HI [VEC_N] = '{  0, 128, 128,   0,   0, 255,    0,    0,    0,  255};
   localparam int V_LO [VEC_N] = '{128,   0, 128, 255, 255,   0,  128,  255,  255,    0};
   localparam int V_N  [VEC_N] = '{ 33,  33,  33,   5,   6,   6, 1057, 1029, 1030, 1029};
   localparam int V_EX [VEC_N] = '{496, 623,1119,   0, 127, 159, -496, -127,    0, -159};

   function automatic string vec_tag(input int i);
      case (i)
         0, 3, 4, 6: return "R2";
         1, 5, 9:    return "R3";
         2:          return "R4";
         default:    return "R1";
      endcase
   endfunction

   function automatic int wave(input int idx, input bit hi);
      int h;
      int m;
      h = idx % 128;
      m = h * (128 - h);
      if (hi) m = (m * 161) / 128;
      return (idx >= 128) ? -m : m;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse();
      @(negedge clk) ce = 1'b1;
      @(negedge clk) ce = 1'b0;
   endtask

   task automatic restart(input int h, input int l);
      @(negedge clk) begin en = 1'b0; ce = 1'b0; end
      @(negedge clk) begin hi_code = 8'(h); lo_code = 8'(l); en = 1'b1; end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int ones;
      int ph_h;
      int ph_l;
      int ex;

      // R9: reset state
      repeat (4) @(negedge clk);
      check("R9 sample", int'(sample), 0);
      check("R9 vld", int'(vld), 0);
      check("R9 buzz", int'(buzz), 0);
      rst_n = 1'b1;

      // vector table walk (R1 R2 R3 R4)
      for (int i = 0; i < VEC_N; i++) begin
         restart(V_HI[i], V_LO[i]);
         for (int k = 0; k < V_N[i]; k++) pulse();
         check(vec_tag(i), int'(sample), V_EX[i]);
      end

      // R6: strobe lasts exactly one cycle
      restart(0, 128);
      pulse();
      check("R6 vld after pulse", int'(vld), 1);
      @(negedge clk);
      check("R6 vld one cycle", int'(vld), 0);

      // R5: zero code silences and holds phase
      restart(0, 128);
      for (int k = 0; k < 33; k++) pulse();
      lo_code = 8'd0;
      for (int k = 0; k < 10; k++) pulse();
      check("R5 muted", int'(sample), 0);
      lo_code = 8'd128;
      pulse();
      check("R5 resume", int'(sample), 496);

      // R8: disable mid-tone, pulses ignored, restart from zero phase
      restart(0, 128);
      for (int k = 0; k < 40; k++) pulse();
      @(negedge clk) en = 1'b0;
      pulse();
      pulse();
      check("R8 sample", int'(sample), 0);
      check("R8 vld", int'(vld), 0);
      check("R8 buzz", int'(buzz), 0);
      @(negedge clk) en = 1'b1;
      for (int k = 0; k < 9; k++) pulse();
      check("R8 restart phase", int'(sample), 127);

      // R7: silent input gives 0,1,0,1 and exact half density
      restart(0, 0);
      pulse();
      check("R7 first bit", int'(buzz), 0);
      pulse();
      check("R7 second bit", int'(buzz), 1);
      ones = 1;
      for (int k = 0; k < 254; k++) begin
         pulse();
         ones += int'(buzz);
      end
      check("R7 silent density", ones, 128);

      // R7: one full tone period averages to half density
      restart(0, 64);
      pulse();
      ones = 0;
      for (int k = 0; k < 4096; k++) begin
         pulse();
         ones += int'(buzz);
      end
      check("R7 tone density", ones, 2048);

      // R1 R4 R6: dual tone with the enable held high every cycle
      restart(170, 89);
      ph_h = 0;
      ph_l = 0;
      @(negedge clk) ce = 1'b1;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         ex = wave(ph_h / 1024, 1'b1) + wave(ph_l / 1024, 1'b0);
         check("R4 dual tone", int'(sample), ex);
         check("R6 held strobe", int'(vld), 1);
         ph_h = (ph_h + 170) % 262144;
         ph_l = (ph_l + 89) % 262144;
      end
      ce = 1'b0;

      @(negedge clk);
      finish_run();
   end
endmodule